// File: doc/BRIEF.md
# Five-Stage 16-bit Processor Core

This block is a small in-order processor core that moves every 16-bit instruction through five registered stages: fetch, decode, execute, memory access and writeback. It holds sixteen 16-bit registers and decodes eight major instructions from a 3-bit opcode. These are four-way arithmetic/logic, two conditional branches, an absolute jump, a load, a store, a no-operation and a halt. Both memory ports address 8192 words, and loads and stores carry the full 13-bit word address in the instruction.

The core has no interlocks and no operand forwarding. The instruction stream must therefore be scheduled so that a consumer sits at least three instructions behind its producer. Taken branches and jumps resolve in execute, and the two instructions fetched after them are squashed. Each memory port registers its address inside the core and expects the addressed word back before the end of the same cycle. Loads always deliver into register 7, and stores always take their data from register 8.

Top module: `mini16_core`

## Requirements
- R1: While reset is held low, imem_addr_o is 0, halted_o is 0 and dmem_we_o is 0, and all registers read as zero once reset is released.
- R2: Bits [15:13] select the operation: 0 arithmetic, 1 jump, 2 load, 3 store, 4 no-operation, 5 halt, 6 branch if equal, 7 branch if not equal.
- R3: An arithmetic word writes register [12:9] with source A register [8:5] combined with source B register {0,[4:2]}, where [1:0] = 0 adds, 1 subtracts (A−B), 2 ANDs and 3 ORs, and results wrap at 16 bits.
- R4: Register 0 always reads as zero, and any write aimed at it leaves it zero.
- R5: A load with address [12:0] writes that data word into register 7, and a store writes register 8 to that word, for any of the 8192 addresses.
- R6: A branch compares register {0,[12:10]} with register {0,[9:7]}. When taken (equal for opcode 6, unequal for opcode 7), it continues at PC+1+[5:0] if bit [6] is 0, or at PC+1−[5:0] if bit [6] is 1, modulo 8192.
- R7: A jump continues at address [12:0].
- R8: The two instructions that follow a taken branch or a jump in address order have no effect.
- R9: A register result is seen by an instruction placed three or more slots after its producer. Instructions one or two slots after it read the previous value.
- R10: A halt that is not squashed sets halted_o, which then stays high. imem_addr_o freezes at the halt's address plus one, older instructions still complete, and no younger one takes effect.
- R11: Without a redirect or halt, imem_addr_o advances by one every cycle, starting from 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 13 | Fetch word address (program counter) |
| imem_data_i | input | 16 | Instruction word at imem_addr_o, valid within the cycle |
| dmem_addr_o | output | 13 | Data word address of the instruction in the memory stage |
| dmem_we_o | output | 1 | Data write strobe, taken at the rising edge |
| dmem_wdata_o | output | 16 | Store data |
| dmem_rdata_i | input | 16 | Load data at dmem_addr_o, valid within the cycle |
| halted_o | output | 1 | Core has executed a halt and stopped fetching |

## Verification
Seeded random programs mix arithmetic with all four sub-operations, loads and stores at scattered addresses, and forward branches whose conditions come out either way. A sequential instruction-level model in the bench produces the final memory image, and any decode, operand-field or branch-target error makes the two images differ. A directed program covers the cases random code rarely reaches. These are a 63-word forward skip, a backward counting loop, writes to register 0, a jump to the top of the address space, and an access at address 0x1FFF, with live instructions placed in the squash slots so that a missing flush becomes visible. A separate program places readers one, two and three slots behind a producer, which separates the writeback bypass from a missing forward path.

// File: rtl/mini16_pkg.sv
package mini16_pkg;
  localparam int XLEN = 16;
  localparam int AW   = 13;
  localparam int NREG = 16;
  localparam int RAW  = $clog2(NREG);
  localparam int OFFW = 6;

  typedef enum logic [2:0] {
    OP_ALU = 3'd0, OP_JMP = 3'd1, OP_LD  = 3'd2, OP_ST  = 3'd3,
    OP_NOP = 3'd4, OP_HLT = 3'd5, OP_BEQ = 3'd6, OP_BNE = 3'd7
  } opc_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_e;

  localparam logic [XLEN-1:0] NOP_WORD = 16'h8000;  // OP_NOP, zero operand
  localparam logic [RAW-1:0]  LD_REG   = RAW'(7);
  localparam logic [RAW-1:0]  ST_REG   = RAW'(8);

  // fields carried from decode into execute
  typedef struct packed {
    logic            rf_we;
    logic            wb_mem;
    logic            mwr;
    logic [RAW-1:0]  rd;
    alu_e            aop;
    logic            jmp;
    logic            beq;
    logic            bne;
    logic            dir;
    logic [OFFW-1:0] off;
    logic [AW-1:0]   addr;
  } ctrl_t;
endpackage

// File: rtl/mini16_decoder.sv
module mini16_decoder
  import mini16_pkg::*;
(
  input  logic [XLEN-1:0] ir_i,
  output ctrl_t           ctrl_o,
  output logic [RAW-1:0]  ra_o,
  output logic [RAW-1:0]  rb_o,
  output logic            hlt_o
);
  opc_e opc;
  assign opc = opc_e'(ir_i[15:13]);

  always_comb begin
    ctrl_o      = '0;
    ctrl_o.addr = ir_i[AW-1:0];
    ctrl_o.off  = ir_i[OFFW-1:0];
    ctrl_o.dir  = ir_i[6];
    ctrl_o.aop  = alu_e'(ir_i[1:0]);
    ra_o        = '0;
    rb_o        = '0;
    hlt_o       = 1'b0;
    unique case (opc)
      OP_ALU: begin
        ctrl_o.rf_we = 1'b1;
        ctrl_o.rd    = ir_i[12:9];
        ra_o         = ir_i[8:5];
        rb_o         = {1'b0, ir_i[4:2]};
      end
      OP_JMP: ctrl_o.jmp = 1'b1;
      OP_LD: begin
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.wb_mem = 1'b1;
        ctrl_o.rd     = LD_REG;
      end
      OP_ST: begin
        ctrl_o.mwr = 1'b1;
        rb_o       = ST_REG;
      end
      OP_HLT: hlt_o = 1'b1;
      OP_BEQ, OP_BNE: begin
        ctrl_o.beq = (opc == OP_BEQ);
        ctrl_o.bne = (opc == OP_BNE);
        ra_o       = {1'b0, ir_i[12:10]};
        rb_o       = {1'b0, ir_i[9:7]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mini16_regfile.sv
module mini16_regfile
  import mini16_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RAW-1:0]  waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [RAW-1:0]  raddr_a_i,
  output logic [XLEN-1:0] rdata_a_o,
  input  logic [RAW-1:0]  raddr_b_i,
  output logic [XLEN-1:0] rdata_b_o
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++)
        if (we_i && waddr_i == RAW'(i)) regs_q[i] <= wdata_i;
    end
  end

  // write-before-read: same-cycle writeback is visible to decode
  function automatic logic [XLEN-1:0] rd_port(input logic [RAW-1:0] a);
    if (a == '0) return '0;
    if (we_i && waddr_i == a) return wdata_i;
    return regs_q[a];
  endfunction

  assign rdata_a_o = rd_port(raddr_a_i);
  assign rdata_b_o = rd_port(raddr_b_i);
endmodule

// File: rtl/mini16_alu.sv
module mini16_alu
  import mini16_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_e            op_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      default: y_o = a_i | b_i;
    endcase
  end
endmodule

// File: rtl/mini16_core.sv
module mini16_core
  import mini16_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [AW-1:0]   imem_addr_o,
  input  logic [XLEN-1:0] imem_data_i,
  output logic [AW-1:0]   dmem_addr_o,
  output logic            dmem_we_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i,
  output logic            halted_o
);
  // fetch
  logic [AW-1:0]   pc_q;
  logic            halted_q;
  // IF/ID
  logic [XLEN-1:0] ifid_ir_q;
  logic [AW-1:0]   ifid_pc_q;
  // ID/EX
  ctrl_t           idex_c_q;
  logic [AW-1:0]   idex_pc_q;
  logic [XLEN-1:0] idex_a_q, idex_b_q;
  // EX/MEM
  logic            exmem_we_q, exmem_wbm_q, exmem_mwr_q;
  logic [RAW-1:0]  exmem_rd_q;
  logic [XLEN-1:0] exmem_res_q, exmem_sd_q;
  logic [AW-1:0]   exmem_addr_q;
  // MEM/WB
  logic            memwb_we_q;
  logic [RAW-1:0]  memwb_rd_q;
  logic [XLEN-1:0] memwb_data_q;

  // decode
  ctrl_t           id_c;
  logic [RAW-1:0]  id_ra, id_rb;
  logic            id_hlt;
  logic [XLEN-1:0] id_a, id_b;

  mini16_decoder u_dec (
    .ir_i   (ifid_ir_q),
    .ctrl_o (id_c),
    .ra_o   (id_ra),
    .rb_o   (id_rb),
    .hlt_o  (id_hlt)
  );

  mini16_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (memwb_we_q),
    .waddr_i   (memwb_rd_q),
    .wdata_i   (memwb_data_q),
    .raddr_a_i (id_ra),
    .rdata_a_o (id_a),
    .raddr_b_i (id_rb),
    .rdata_b_o (id_b)
  );

  // execute
  logic [XLEN-1:0] ex_res;
  logic [AW-1:0]   ex_seq_pc, ex_br_tgt, ex_tgt;
  logic            ex_take, ex_redirect, halt_set;

  mini16_alu u_alu (
    .a_i  (idex_a_q),
    .b_i  (idex_b_q),
    .op_i (idex_c_q.aop),
    .y_o  (ex_res)
  );

  assign ex_seq_pc   = idex_pc_q + AW'(1);
  assign ex_br_tgt   = idex_c_q.dir ? ex_seq_pc - AW'(idex_c_q.off)
                                    : ex_seq_pc + AW'(idex_c_q.off);
  assign ex_take     = (idex_c_q.beq && (idex_a_q == idex_b_q)) ||
                       (idex_c_q.bne && (idex_a_q != idex_b_q));
  assign ex_redirect = idex_c_q.jmp || ex_take;
  assign ex_tgt      = idex_c_q.jmp ? idex_c_q.addr : ex_br_tgt;
  // a halt squashed by an older redirect must not stop the core
  assign halt_set    = id_hlt && !ex_redirect && !halted_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      halted_q <= halted_q | halt_set;
      if (!halted_q) begin
        if (ex_redirect)    pc_q <= ex_tgt;
        else if (!halt_set) pc_q <= pc_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifid_ir_q <= NOP_WORD;
      ifid_pc_q <= '0;
    end else if (ex_redirect || halt_set || halted_q) begin
      ifid_ir_q <= NOP_WORD;
    end else begin
      ifid_ir_q <= imem_data_i;
      ifid_pc_q <= pc_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idex_c_q  <= '0;
      idex_pc_q <= '0;
      idex_a_q  <= '0;
      idex_b_q  <= '0;
    end else begin
      idex_c_q  <= ex_redirect ? '0 : id_c;
      idex_pc_q <= ifid_pc_q;
      idex_a_q  <= id_a;
      idex_b_q  <= id_b;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exmem_we_q   <= 1'b0;
      exmem_wbm_q  <= 1'b0;
      exmem_mwr_q  <= 1'b0;
      exmem_rd_q   <= '0;
      exmem_res_q  <= '0;
      exmem_sd_q   <= '0;
      exmem_addr_q <= '0;
    end else begin
      exmem_we_q   <= idex_c_q.rf_we;
      exmem_wbm_q  <= idex_c_q.wb_mem;
      exmem_mwr_q  <= idex_c_q.mwr;
      exmem_rd_q   <= idex_c_q.rd;
      exmem_res_q  <= ex_res;
      exmem_sd_q   <= idex_b_q;
      exmem_addr_q <= idex_c_q.addr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      memwb_we_q   <= 1'b0;
      memwb_rd_q   <= '0;
      memwb_data_q <= '0;
    end else begin
      memwb_we_q   <= exmem_we_q;
      memwb_rd_q   <= exmem_rd_q;
      memwb_data_q <= exmem_wbm_q ? dmem_rdata_i : exmem_res_q;
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = exmem_addr_q;
  assign dmem_we_o    = exmem_mwr_q;
  assign dmem_wdata_o = exmem_sd_q;
  assign halted_o     = halted_q;
endmodule

// File: rtl/mini16_core_chk.sv
module mini16_core_chk
  import mini16_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            halted_i,
  input logic [AW-1:0]   imem_addr_i,
  input logic            redirect_i,
  input ctrl_t           idex_c_i,
  input logic [XLEN-1:0] ifid_ir_i,
  input logic [RAW-1:0]  rf_raddr_i,
  input logic [XLEN-1:0] rf_rdata_i
);
  // R10
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);

  // R10
  pc_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> $stable(imem_addr_i));

  // R11
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted_i && !redirect_i) |=>
      (halted_i || imem_addr_i == $past(imem_addr_i) + AW'(1)));

  // R8
  flush_ex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> !(idex_c_i.rf_we || idex_c_i.mwr || idex_c_i.jmp ||
                     idex_c_i.beq || idex_c_i.bne));

  // R8
  flush_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |=> ifid_ir_i == NOP_WORD);

  // R4
  r0_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_raddr_i == '0) |-> (rf_rdata_i == '0));
endmodule

bind mini16_core mini16_core_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halted_i    (halted_o),
  .imem_addr_i (imem_addr_o),
  .redirect_i  (ex_redirect),
  .idex_c_i    (idex_c_q),
  .ifid_ir_i   (ifid_ir_q),
  .rf_raddr_i  (id_ra),
  .rf_rdata_i  (id_a)
);

// File: tb/mini16_core_tb_top.sv
`timescale 1ns/1ps
module mini16_core_tb_top;
  localparam logic [15:0] NOPW = 16'h8000;
  localparam int DUMP = 'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] imem_addr;
  logic [15:0] imem_data = NOPW;
  logic [12:0] dmem_addr;
  logic        dmem_we;
  logic [15:0] dmem_wdata;
  logic [15:0] dmem_rdata = '0;
  logic        halted;

  int n_cmp = 0;
  int n_bad = 0;
  int wp;

  logic [15:0] prog    [int];
  logic [15:0] dmem    [int];
  logic [15:0] dinit   [int];
  logic [15:0] ref_mem [int];

  always #4 clk = ~clk;

  mini16_core dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .imem_addr_o  (imem_addr),
    .imem_data_i  (imem_data),
    .dmem_addr_o  (dmem_addr),
    .dmem_we_o    (dmem_we),
    .dmem_wdata_o (dmem_wdata),
    .dmem_rdata_i (dmem_rdata),
    .halted_o     (halted)
  );

  // memories answer half a cycle after the address settles
  always @(negedge clk) begin
    imem_data  <= prog.exists(int'(imem_addr)) ? prog[int'(imem_addr)] : NOPW;
    dmem_rdata <= dmem.exists(int'(dmem_addr)) ? dmem[int'(dmem_addr)] : 16'h0;
  end
  always @(posedge clk) if (rst_n && dmem_we) dmem[int'(dmem_addr)] = dmem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // encoders (R2 opcode map)
  function automatic logic [15:0] i_alu(int rd, int ra, int rb, int op);
    return {3'd0, 4'(rd), 4'(ra), 3'(rb), 2'(op)};
  endfunction
  function automatic logic [15:0] i_jmp(int a); return {3'd1, 13'(a)}; endfunction
  function automatic logic [15:0] i_ld(int a);  return {3'd2, 13'(a)}; endfunction
  function automatic logic [15:0] i_st(int a);  return {3'd3, 13'(a)}; endfunction
  function automatic logic [15:0] i_br(bit ne, int c1, int c2, bit dir, int off);
    return {ne ? 3'd7 : 3'd6, 3'(c1), 3'(c2), dir, 6'(off)};
  endfunction

  task automatic put(input logic [15:0] w); prog[wp] = w; wp = (wp + 1) & 8191; endtask
  task automatic putp(input logic [15:0] w); put(w); put(NOPW); put(NOPW); endtask

  task automatic dump_regs();
    putp(i_st(DUMP + 8));
    for (int k = 0; k < 16; k++) begin
      if (k != 8) begin
        putp(i_alu(8, k, 0, 0));
        putp(i_st(DUMP + k));
      end
    end
    put(16'hA000);  // halt
  endtask

  // sequential instruction-level model
  task automatic iss_run(output int hpc);
    logic [15:0] rf [16];
    int pc, npc, a;
    logic [15:0] w, x, y, z;
    bit take;
    ref_mem = dinit;
    for (int i = 0; i < 16; i++) rf[i] = '0;
    pc = 0; hpc = -1;
    for (int s = 0; s < 40000; s++) begin
      w   = prog.exists(pc) ? prog[pc] : NOPW;
      npc = (pc + 1) & 8191;
      a   = int'(w[12:0]);
      case (w[15:13])
        3'd0: begin
          x = rf[w[8:5]]; y = rf[{1'b0, w[4:2]}];
          case (w[1:0])
            2'd0: z = x + y;
            2'd1: z = x - y;
            2'd2: z = x & y;
            default: z = x | y;
          endcase
          if (w[12:9] != 4'd0) rf[w[12:9]] = z;
        end
        3'd1: npc = a;
        3'd2: rf[7] = ref_mem.exists(a) ? ref_mem[a] : 16'h0;
        3'd3: ref_mem[a] = rf[8];
        3'd5: begin hpc = pc; return; end
        3'd6, 3'd7: begin
          take = (rf[{1'b0, w[12:10]}] == rf[{1'b0, w[9:7]}]) ^ w[13];
          if (take) npc = w[6] ? (pc + 1 - int'(w[5:0])) & 8191
                               : (pc + 1 + int'(w[5:0])) & 8191;
        end
        default: ;
      endcase
      pc = npc;
    end
  endtask

  task automatic run_prog(input string tag, input bit use_iss);
    int n, hpc;
    logic [12:0] hold;
    dmem = dinit;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(imem_addr == 13'd0 && !halted && !dmem_we, "R1", "reset outputs",
        {imem_addr, halted, dmem_we}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(imem_addr == 13'd1, "R11", "fetch step 1", imem_addr, 1);
    @(negedge clk);
    chk(imem_addr == 13'd2, "R11", "fetch step 2", imem_addr, 2);
    n = 0;
    while (!halted && n < 4000) begin @(negedge clk); n++; end
    chk(halted, "R10", "halt reached", halted, 1);
    hold = imem_addr;
    repeat (4) @(negedge clk);
    repeat (6) begin
      @(negedge clk);
      chk(halted && imem_addr == hold && !dmem_we, "R10", "frozen after halt",
          {imem_addr, halted, dmem_we}, {hold, 2'b10});
    end
    if (use_iss) begin
      iss_run(hpc);
      chk(int'(imem_addr) == ((hpc + 1) & 8191), "R10", "halt pc", imem_addr, (hpc + 1) & 8191);
      foreach (ref_mem[k])
        chk(dmem.exists(k) && dmem[k] == ref_mem[k], tag, $sformatf("mem[%0h]", k),
            dmem.exists(k) ? dmem[k] : 32'hFFFF_FFFF, ref_mem[k]);
    end
  endtask

  task automatic gen_random(input int len);
    int r;
    prog.delete(); wp = 0;
    for (int i = 0; i < 4; i++) begin
      putp(i_ld($urandom_range(0, 63)));
      putp(i_alu($urandom_range(1, 15), 7, 0, 0));
    end
    for (int i = 0; i < len; i++) begin
      r = $urandom_range(0, 99);
      if (r < 55)      putp(i_alu($urandom_range(0, 15), $urandom_range(0, 15),
                                  $urandom_range(0, 7), $urandom_range(0, 3)));
      else if (r < 70) putp(i_ld($urandom_range(0, 63)));
      else if (r < 80) putp(i_st('h0800 + $urandom_range(0, 63)));
      else             putp(i_br(1'($urandom_range(0, 1)), $urandom_range(0, 7),
                                 $urandom_range(0, 7), 1'b0, $urandom_range(1, 12)));
    end
    dump_regs();
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int a = 0; a < 64; a++) dinit[a] = 16'($urandom);
    dinit[5] = 16'd1;
    dinit[6] = 16'd3;
    dinit['h1FFF] = 16'hBEEF;

    // R2 R3 R4 R5 R6: random mixes checked against the sequential model
    for (int p = 0; p < 6; p++) begin
      gen_random(30);
      run_prog("R3", 1'b1);
    end

    // directed: R4 R5 R6 R7 R8
    prog.delete(); wp = 0;
    putp(i_ld('h1FFF)); putp(i_alu(1, 7, 0, 0));       // r1 = BEEF
    putp(i_ld(5));      putp(i_alu(2, 7, 0, 0));       // r2 = 1
    put(i_br(0, 0, 0, 0, 63));                          // R6 max forward skip
    for (int i = 0; i < 63; i++) put(i_alu(13, 1, 2, 0));
    put(i_br(0, 2, 2, 0, 2));                           // R8 taken, two squashed
    put(i_alu(3, 1, 2, 0)); put(i_alu(4, 1, 1, 3));
    putp(i_br(1, 2, 2, 0, 5));                          // not taken
    putp(i_alu(5, 1, 2, 1));
    putp(i_ld(6)); putp(i_alu(6, 7, 0, 0));             // r6 = 3
    putp(i_alu(6, 6, 2, 1));                            // loop top
    putp(i_alu(9, 9, 1, 0));
    put(i_br(1, 6, 0, 1, 7));                           // R6 backward
    put(i_alu(11, 1, 1, 0)); put(i_alu(12, 1, 2, 2));
    put(NOPW); put(NOPW);
    putp(i_alu(15, 1, 7, 2));
    putp(i_alu(0, 1, 1, 0));                            // R4 write to r0
    putp(i_alu(8, 1, 0, 0)); putp(i_st('h1FFE));        // R5 top address
    put(i_jmp('h1F00));                                 // R7
    put(i_alu(13, 1, 1, 0)); put(i_alu(14, 1, 1, 0));
    wp = 'h1F00;
    putp(i_alu(10, 1, 2, 0));
    dump_regs();
    run_prog("R8", 1'b1);
    chk(dmem.exists('h1FFE) && dmem['h1FFE] == 16'hBEEF, "R5", "store r8 at 1FFE",
        dmem.exists('h1FFE) ? dmem['h1FFE] : 32'hFFFF_FFFF, 16'hBEEF);
    chk(dmem.exists(DUMP) && dmem[DUMP] == 16'h0, "R4", "r0 after write",
        dmem.exists(DUMP) ? dmem[DUMP] : 32'hFFFF_FFFF, 0);
    chk(dmem.exists(DUMP + 3) && dmem[DUMP + 3] == 16'h0, "R8", "squashed r3",
        dmem.exists(DUMP + 3) ? dmem[DUMP + 3] : 32'hFFFF_FFFF, 0);
    chk(dmem.exists(DUMP + 10) && dmem[DUMP + 10] == 16'hBEF0, "R7", "code at jump target",
        dmem.exists(DUMP + 10) ? dmem[DUMP + 10] : 32'hFFFF_FFFF, 16'hBEF0);
    chk(dmem.exists(DUMP + 9) && dmem[DUMP + 9] == 16'((3 * 32'hBEEF) & 16'hFFFF), "R6",
        "loop sum r9", dmem.exists(DUMP + 9) ? dmem[DUMP + 9] : 32'hFFFF_FFFF,
        (3 * 32'hBEEF) & 16'hFFFF);

    // R9: readers one, two and three slots behind the producer
    prog.delete(); wp = 0;
    putp(i_ld(5));
    put(i_alu(1, 7, 0, 0));
    put(i_alu(2, 1, 0, 0));
    put(i_alu(4, 1, 0, 0));
    put(i_alu(3, 1, 0, 0));
    put(NOPW); put(NOPW);
    dump_regs();
    run_prog("R9", 1'b0);
    chk(dmem.exists(DUMP + 2) && dmem[DUMP + 2] == 16'h0, "R9", "slot+1 old value",
        dmem.exists(DUMP + 2) ? dmem[DUMP + 2] : 32'hFFFF_FFFF, 0);
    chk(dmem.exists(DUMP + 4) && dmem[DUMP + 4] == 16'h0, "R9", "slot+2 old value",
        dmem.exists(DUMP + 4) ? dmem[DUMP + 4] : 32'hFFFF_FFFF, 0);
    chk(dmem.exists(DUMP + 3) && dmem[DUMP + 3] == 16'h1, "R9", "slot+3 new value",
        dmem.exists(DUMP + 3) ? dmem[DUMP + 3] : 32'hFFFF_FFFF, 1);
    chk(dmem.exists(DUMP + 7) && dmem[DUMP + 7] == 16'h1, "R5", "load into r7",
        dmem.exists(DUMP + 7) ? dmem[DUMP + 7] : 32'hFFFF_FFFF, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule